// File: doc/BRIEF.md
# Floating-point status register unit

This block holds the 32-bit status and control word of a floating-point unit and keeps its summary bits consistent. An arithmetic unit reports each finished operation as a flag vector plus a four-bit result-class code. The block merges those flags into the word as sticky bits and reloads the class code. Once every item is merged, it derives the three summary bits: FX (new exception), FEX (enabled exception) and VX (invalid). Software never writes these three bits directly.

Besides operation results, the block runs five control commands. Set-bit and clear-bit address the word with big-endian bit numbers. An immediate write stores four bits into one nibble. A masked write copies chosen nibbles from a source word. A copy command moves one nibble into a condition-register field and clears the sticky exception bits it moved. Each accepted item can raise a one-cycle trap request. It can also raise a one-cycle condition-register field write.

Items arrive at most one per clock, marked by a valid strobe. All results appear on registered outputs.

Top module: `fpsr_unit`

## Requirements
- R1: After reset the status word is zero, and trap_req and cr_we are low.
- R2: An operation item (in_kind 0) ORs in only the sticky flag positions of op_flags (bits 28..19 and 10..8; LSB numbering) and ignores all its other bits. It also loads op_fpcc into bits 15..12.
- R3: Bit 29 (VX) is 1 exactly when any invalid-cause bit (24..19 or 10..8) is 1.
- R4: Bit 30 (FEX) is 1 exactly when any flag at 29..25 is 1 together with its enable at 7..3 (the enables shifted left by 22 line up with the flags).
- R5: FX (bit 31) is set when an operation or a set-bit command turns on an exception bit (29..19 or 10..8) that was clear. Otherwise FX holds its written value.
- R6: Set-bit (in_kind 1) and clear-bit (in_kind 2) with cmd_bit n act on LSB position 31-n. Aimed at n=1 (FEX) or n=2 (VX), they leave the word unchanged.
- R7: Immediate write (in_kind 3) stores cmd_imm into nibble k = cmd_field, which covers bits 31-4k..28-4k. Any FEX or VX inside that nibble is then recomputed.
- R8: Masked write (in_kind 4) copies cmd_src into bits 4i+3..4i for each set bit i of cmd_mask. A mask of 0xFF replaces the whole word, summary bits recomputed.
- R9: Copy-to-CR (in_kind 5) puts the old nibble cmd_field on cr_data and cr_target on cr_field. Within that nibble it clears only FX, OX, UX, ZX, XX and the invalid causes.
- R10: An operation with op_record writes the new top nibble (31..28) to CR field 1. An operation with op_compare writes op_fpcc to cr_target instead, and compare wins if both are set.
- R11: trap_req pulses for one cycle after each accepted item whose new word has FEX = 1.
- R12: Idle cycles and in_kind 6 or 7 leave the word unchanged, with no trap and no CR write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An item is presented this cycle |
| in_kind | input | 3 | 0 op, 1 set bit, 2 clear bit, 3 immediate, 4 masked, 5 copy to CR |
| op_flags | input | 32 | Exception flags of a finished operation |
| op_fpcc | input | 4 | Result-class code of a finished operation |
| op_record | input | 1 | Operation is record form |
| op_compare | input | 1 | Operation is a compare |
| cmd_bit | input | 5 | Big-endian bit number for set/clear |
| cmd_field | input | 3 | Big-endian nibble number |
| cmd_imm | input | 4 | Immediate nibble |
| cmd_mask | input | 8 | Nibble mask for masked write |
| cmd_src | input | 32 | Source word for masked write |
| cr_target | input | 3 | Destination CR field for compare or copy |
| fpsr_q | output | 32 | Status and control word |
| trap_req | output | 1 | Enabled exception pending after the item |
| cr_we | output | 1 | CR field write strobe |
| cr_field | output | 3 | CR field number written |
| cr_data | output | 4 | CR field value written |

## Verification
Every accepted item is due exactly one rising edge later: the new word, trap_req and the CR strobe all come from registers loaded at the edge that samples in_valid. The monitor waits for each rising edge and samples 2 ns later. If the edge took an item, it pops the matching expected record from the queue. If not, it checks that the word held and both pulses fell. So a result that arrives a cycle early or late shows up as a mismatch.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
   localparam int REG_W = 32;

   // item kinds on in_kind
   localparam logic [2:0] K_OP   = 3'd0;
   localparam logic [2:0] K_SETB = 3'd1;
   localparam logic [2:0] K_CLRB = 3'd2;
   localparam logic [2:0] K_FLDI = 3'd3;
   localparam logic [2:0] K_FLDM = 3'd4;
   localparam logic [2:0] K_TOCR = 3'd5;

   // bit positions, LSB numbering
   localparam int POS_FX     = 31;
   localparam int POS_FEX    = 30;
   localparam int POS_VX     = 29;
   localparam int FPCC_LO    = 12;
   localparam int EN_SHIFT   = 22;

   localparam logic [REG_W-1:0] INV_MASK    = 32'h01F8_0700;
   localparam logic [REG_W-1:0] STICKY_MASK = 32'h1FF8_0700;
   localparam logic [REG_W-1:0] EXC_MASK    = 32'h3FF8_0700;
   localparam logic [REG_W-1:0] CLRCP_MASK  = 32'h9FF8_0700;
   localparam logic [REG_W-1:0] SUMM_MASK   = 32'h6000_0000;
   localparam logic [REG_W-1:0] FLAG_GROUP  = 32'h3E00_0000;
   localparam logic [REG_W-1:0] EN_GROUP    = 32'h0000_00F8;
   localparam logic [REG_W-1:0] FPCC_MASK   = 32'h0000_F000;
endpackage

// File: rtl/fpsr_cmd_exec.sv
module fpsr_cmd_exec
   import fpsr_pkg::*;
#(
   parameter int FIELD_W    = 4,
   parameter int NUM_FIELDS = 8,
   parameter int REC_FIELD  = 1,
   localparam int WIDTH     = FIELD_W * NUM_FIELDS,
   localparam int BIT_W     = $clog2(WIDTH),
   localparam int FLD_W     = $clog2(NUM_FIELDS)
) (
   input  logic [WIDTH-1:0]   cur,
   input  logic [2:0]         kind,
   input  logic [WIDTH-1:0]   op_flags,
   input  logic [FIELD_W-1:0] op_fpcc,
   input  logic               op_record,
   input  logic               op_compare,
   input  logic [BIT_W-1:0]   cmd_bit,
   input  logic [FLD_W-1:0]   cmd_field,
   input  logic [FIELD_W-1:0] cmd_imm,
   input  logic [NUM_FIELDS-1:0] cmd_mask,
   input  logic [WIDTH-1:0]   cmd_src,
   input  logic [FLD_W-1:0]   cr_target,
   output logic [WIDTH-1:0]   base,
   output logic               fx_arm,
   output logic               accept,
   output logic               crw,
   output logic               rec_sel,
   output logic [FLD_W-1:0]   crf,
   output logic [FIELD_W-1:0] crd
);
   localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};
   localparam logic [WIDTH-1:0] LOW_NIB = {{(WIDTH-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};

   logic [WIDTH-1:0] bit_m;
   logic [WIDTH-1:0] nib_m;
   logic [WIDTH-1:0] fld_m;
   logic [BIT_W-1:0] nib_sh;
   logic [WIDTH-1:0] nib_val;

   // expand the per-nibble write mask
   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_mexp
      assign fld_m[i*FIELD_W +: FIELD_W] = {FIELD_W{cmd_mask[i]}};
   end

   always_comb begin
      bit_m   = TOP_BIT >> cmd_bit;
      nib_sh  = BIT_W'(WIDTH - FIELD_W) - BIT_W'(FIELD_W) * BIT_W'(cmd_field);
      nib_m   = LOW_NIB << nib_sh;
      nib_val = cur >> nib_sh;
   end

   always_comb begin
      base    = cur;
      fx_arm  = 1'b0;
      accept  = 1'b1;
      crw     = 1'b0;
      rec_sel = 1'b0;
      crf     = '0;
      crd     = '0;
      case (kind)
         K_OP: begin
            base   = (cur & ~FPCC_MASK) | (op_flags & STICKY_MASK)
                     | (WIDTH'(op_fpcc) << FPCC_LO);
            fx_arm = 1'b1;
            if (op_compare) begin
               crw = 1'b1;
               crf = cr_target;
               crd = op_fpcc;
            end else if (op_record) begin
               crw     = 1'b1;
               rec_sel = 1'b1;
               crf     = FLD_W'(REC_FIELD);
            end
         end
         K_SETB: begin
            base   = cur | bit_m;
            fx_arm = 1'b1;
         end
         K_CLRB: base = cur & ~bit_m;
         K_FLDI: base = (cur & ~nib_m) | ((WIDTH'(cmd_imm) << nib_sh) & nib_m);
         K_FLDM: base = (cur & ~fld_m) | (cmd_src & fld_m);
         K_TOCR: begin
            base = cur & ~(nib_m & CLRCP_MASK);
            crw  = 1'b1;
            crf  = cr_target;
            crd  = nib_val[FIELD_W-1:0];
         end
         default: accept = 1'b0;
      endcase
   end
endmodule

// File: rtl/fpsr_summary.sv
module fpsr_summary
   import fpsr_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] base,
   input  logic [WIDTH-1:0] prev,
   input  logic             fx_arm,
   output logic [WIDTH-1:0] word
);
   logic [WIDTH-1:0] clean;
   logic [WIDTH-1:0] with_vx;
   logic             vx_n;
   logic             fex_n;
   logic             fx_n;

   always_comb begin
      clean   = base & ~SUMM_MASK;
      vx_n    = |(clean & INV_MASK);
      with_vx = clean;
      with_vx[POS_VX] = vx_n;
      // enables shifted up line up with the flags they govern
      fex_n   = |((with_vx & FLAG_GROUP) & ((with_vx & EN_GROUP) << EN_SHIFT));
      fx_n    = with_vx[POS_FX] | (fx_arm & (|((with_vx ^ prev) & EXC_MASK)));
      word    = with_vx;
      word[POS_FEX] = fex_n;
      word[POS_FX]  = fx_n;
   end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
   import fpsr_pkg::*;
#(
   parameter int FIELD_W    = 4,
   parameter int NUM_FIELDS = 8,
   parameter int REC_FIELD  = 1,
   localparam int WIDTH     = FIELD_W * NUM_FIELDS,
   localparam int BIT_W     = $clog2(WIDTH),
   localparam int FLD_W     = $clog2(NUM_FIELDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [2:0]            in_kind,
   input  logic [WIDTH-1:0]      op_flags,
   input  logic [FIELD_W-1:0]    op_fpcc,
   input  logic                  op_record,
   input  logic                  op_compare,
   input  logic [BIT_W-1:0]      cmd_bit,
   input  logic [FLD_W-1:0]      cmd_field,
   input  logic [FIELD_W-1:0]    cmd_imm,
   input  logic [NUM_FIELDS-1:0] cmd_mask,
   input  logic [WIDTH-1:0]      cmd_src,
   input  logic [FLD_W-1:0]      cr_target,
   output logic [WIDTH-1:0]      fpsr_q,
   output logic                  trap_req,
   output logic                  cr_we,
   output logic [FLD_W-1:0]      cr_field,
   output logic [FIELD_W-1:0]    cr_data
);
   // bit positions in the package assume the standard word shape
   if (WIDTH != REG_W || FIELD_W != 4) begin : g_bad_shape
      $error("fpsr_unit: word must be 32 bits of 4-bit fields");
   end
   if (REC_FIELD < 0 || REC_FIELD >= NUM_FIELDS) begin : g_bad_rec
      $error("fpsr_unit: record field out of range");
   end

   logic [WIDTH-1:0]   base;
   logic [WIDTH-1:0]   word_n;
   logic               fx_arm;
   logic               accept;
   logic               crw_n;
   logic               rec_sel;
   logic [FLD_W-1:0]   crf_n;
   logic [FIELD_W-1:0] crd_n;
   logic               take;

   fpsr_cmd_exec #(
      .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .REC_FIELD(REC_FIELD)
   ) u_exec (
      .cur(fpsr_q), .kind(in_kind), .op_flags(op_flags), .op_fpcc(op_fpcc),
      .op_record(op_record), .op_compare(op_compare), .cmd_bit(cmd_bit),
      .cmd_field(cmd_field), .cmd_imm(cmd_imm), .cmd_mask(cmd_mask),
      .cmd_src(cmd_src), .cr_target(cr_target), .base(base), .fx_arm(fx_arm),
      .accept(accept), .crw(crw_n), .rec_sel(rec_sel), .crf(crf_n), .crd(crd_n)
   );

   fpsr_summary #(.WIDTH(WIDTH)) u_sum (
      .base(base), .prev(fpsr_q), .fx_arm(fx_arm), .word(word_n)
   );

   assign take = in_valid & accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fpsr_q   <= '0;
         trap_req <= 1'b0;
         cr_we    <= 1'b0;
         cr_field <= '0;
         cr_data  <= '0;
      end else begin
         trap_req <= take & word_n[POS_FEX];
         cr_we    <= take & crw_n;
         if (take) begin
            fpsr_q <= word_n;
         end
         if (take && crw_n) begin
            cr_field <= crf_n;
            cr_data  <= rec_sel ? word_n[WIDTH-1 -: FIELD_W] : crd_n;
         end
      end
   end
endmodule

// File: rtl/fpsr_unit_chk.sv
module fpsr_unit_chk
   import fpsr_pkg::*;
#(
   parameter int FIELD_W    = 4,
   parameter int NUM_FIELDS = 8,
   localparam int WIDTH     = FIELD_W * NUM_FIELDS
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [2:0]         in_kind,
   input logic [WIDTH-1:0]   op_flags,
   input logic [FIELD_W-1:0] op_fpcc,
   input logic [WIDTH-1:0]   fpsr_q,
   input logic               trap_req,
   input logic               cr_we
);
   p_vx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fpsr_q[POS_VX] == (|(fpsr_q & INV_MASK)));

   p_fex_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fpsr_q[POS_FEX] == (|(fpsr_q[29:25] & fpsr_q[7:3])));

   p_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_kind <= K_TOCR) |=> trap_req == fpsr_q[POS_FEX]);

   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_kind == K_OP |=>
         ((fpsr_q & STICKY_MASK) & ($past(fpsr_q | op_flags) & STICKY_MASK))
            == ($past(fpsr_q | op_flags) & STICKY_MASK));

   p_fpcc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_kind == K_OP |=> fpsr_q[15:12] == $past(op_fpcc));

   p_fx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_kind == K_OP && ((op_flags & STICKY_MASK & ~fpsr_q) != '0)
         |=> fpsr_q[POS_FX]);

   p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !cr_we && !trap_req && $stable(fpsr_q));
endmodule

bind fpsr_unit fpsr_unit_chk #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
   .op_flags(op_flags), .op_fpcc(op_fpcc), .fpsr_q(fpsr_q),
   .trap_req(trap_req), .cr_we(cr_we)
);

// File: tb/fpsr_unit_test.sv
module fpsr_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_kind = '0;
   logic [31:0] op_flags = '0;
   logic [3:0]  op_fpcc = '0;
   logic        op_record = 1'b0;
   logic        op_compare = 1'b0;
   logic [4:0]  cmd_bit = '0;
   logic [2:0]  cmd_field = '0;
   logic [3:0]  cmd_imm = '0;
   logic [7:0]  cmd_mask = '0;
   logic [31:0] cmd_src = '0;
   logic [2:0]  cr_target = '0;
   logic [31:0] fpsr_q;
   logic        trap_req;
   logic        cr_we;
   logic [2:0]  cr_field;
   logic [3:0]  cr_data;

   always #5 clk = ~clk;

   fpsr_unit uut (.*);

   typedef struct {
      logic [2:0]  kind;
      logic [31:0] flags;
      logic [3:0]  fpcc;
      logic        rec;
      logic        cmp;
      logic [4:0]  bitn;
      logic [2:0]  fld;
      logic [3:0]  imm;
      logic [7:0]  mask;
      logic [31:0] src;
      logic [2:0]  tgt;
   } stim_t;

   typedef struct {
      logic [31:0] word;
      logic        trap;
      logic        crw;
      logic [2:0]  crf;
      logic [3:0]  crd;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [31:0] model_word = '0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   // reference built from the requirement text
   function automatic exp_t model(logic [31:0] cur, stim_t s, string tag);
      exp_t e;
      logic [31:0] w, nm;
      logic        arm;
      logic [31:0] inv = 32'h01F8_0700;
      logic [31:0] stk = 32'h1FF8_0700;
      logic [31:0] exc = 32'h3FF8_0700;
      int lo;
      w = cur; arm = 1'b0;
      e.crw = 1'b0; e.crf = '0; e.crd = '0; e.tag = tag;
      lo = 28 - 4 * int'(s.fld);
      nm = 32'hF << lo;
      case (s.kind)
         3'd0: begin                                  // R2
            w = (cur | (s.flags & stk));
            w[15:12] = s.fpcc;
            arm = 1'b1;
         end
         3'd1: begin w[31 - int'(s.bitn)] = 1'b1; arm = 1'b1; end   // R6
         3'd2: w[31 - int'(s.bitn)] = 1'b0;                        // R6
         3'd3: w[lo +: 4] = s.imm;                                 // R7
         3'd4: for (int i = 0; i < 8; i++)                         // R8
                  if (s.mask[i]) w[4*i +: 4] = s.src[4*i +: 4];
         3'd5: begin                                               // R9
            e.crw = 1'b1; e.crf = s.tgt; e.crd = cur[lo +: 4];
            w = cur & ~(nm & 32'h9FF8_0700);
         end
         default: ;
      endcase
      w[30] = 1'b0;
      w[29] = |(w & inv);                                          // R3
      w[30] = |(w[29:25] & w[7:3]);                                // R4
      if (arm && ((w ^ cur) & exc) != 0) w[31] = 1'b1;             // R5
      if (s.kind == 3'd0) begin                                    // R10
         if (s.cmp) begin e.crw = 1'b1; e.crf = s.tgt; e.crd = s.fpcc; end
         else if (s.rec) begin e.crw = 1'b1; e.crf = 3'd1; e.crd = w[31:28]; end
      end
      e.word = (s.kind > 3'd5) ? cur : w;                          // R12
      e.trap = (s.kind <= 3'd5) && w[30];                          // R11
      return e;
   endfunction

   function automatic stim_t blank();
      stim_t s;
      s.kind = 3'd7; s.flags = '0; s.fpcc = '0; s.rec = 1'b0; s.cmp = 1'b0;
      s.bitn = '0; s.fld = '0; s.imm = '0; s.mask = '0; s.src = '0; s.tgt = '0;
      return s;
   endfunction

   task automatic drive(stim_t s, string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; in_kind = s.kind; op_flags = s.flags; op_fpcc = s.fpcc;
      op_record = s.rec; op_compare = s.cmp; cmd_bit = s.bitn; cmd_field = s.fld;
      cmd_imm = s.imm; cmd_mask = s.mask; cmd_src = s.src; cr_target = s.tgt;
      e = model(model_word, s, tag);
      model_word = e.word;
      sb.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // monitor: every result is due one edge after the item
   initial begin
      wait (rst_n);
      forever begin
         logic v;
         exp_t e;
         @(posedge clk);
         v = in_valid;
         #2;
         n_chk++;
         if (v) begin
            if (sb.size() == 0) begin
               n_bad++;
               $display("FAIL R12 unexpected item: actual=none queued expected=queued");
            end else begin
               e = sb.pop_front();
               if (fpsr_q !== e.word || trap_req !== e.trap || cr_we !== e.crw ||
                   (e.crw && (cr_field !== e.crf || cr_data !== e.crd))) begin
                  n_bad++;
                  $display("FAIL %s: actual word=%h trap=%b crw=%b f=%0d d=%h expected word=%h trap=%b crw=%b f=%0d d=%h",
                           e.tag, fpsr_q, trap_req, cr_we, cr_field, cr_data,
                           e.word, e.trap, e.crw, e.crf, e.crd);
               end
            end
         end else if (fpsr_q !== model_word || trap_req !== 1'b0 || cr_we !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 idle: actual word=%h trap=%b crw=%b expected word=%h trap=0 crw=0",
                     fpsr_q, trap_req, cr_we, model_word);
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL R12 watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      stim_t s;
      repeat (3) @(negedge clk);
      n_chk++;                                       // R1 reset state
      if (fpsr_q !== '0 || trap_req !== 1'b0 || cr_we !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: actual word=%h trap=%b crw=%b expected 0/0/0", fpsr_q, trap_req, cr_we);
      end
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // R2 R5: zero-divide flag plus class code, no enables
      s = blank(); s.kind = 3'd0; s.flags = 32'h0400_0000; s.fpcc = 4'h2;
      drive(s, "R2");
      // R7 R4 R11: enable ZE through nibble 6 -> FEX and trap
      s = blank(); s.kind = 3'd3; s.fld = 3'd6; s.imm = 4'h1; drive(s, "R7");
      // R6: clear FX, then try FEX and VX directly
      s = blank(); s.kind = 3'd2; s.bitn = 5'd0; drive(s, "R6");
      s = blank(); s.kind = 3'd2; s.bitn = 5'd1; drive(s, "R6");
      s = blank(); s.kind = 3'd1; s.bitn = 5'd2; drive(s, "R6");
      // R3 R5: set SNaN cause -> VX and FX
      s = blank(); s.kind = 3'd1; s.bitn = 5'd7; drive(s, "R3");
      idle(1);
      // R9: copy nibble 0 then nibble 1
      s = blank(); s.kind = 3'd5; s.fld = 3'd0; s.tgt = 3'd5; drive(s, "R9");
      s = blank(); s.kind = 3'd5; s.fld = 3'd1; s.tgt = 3'd2; drive(s, "R9");
      // R8: full-word write then single-nibble clear
      s = blank(); s.kind = 3'd4; s.mask = 8'hFF; s.src = 32'hFFFF_FFFF; drive(s, "R8");
      s = blank(); s.kind = 3'd4; s.mask = 8'h01; s.src = 32'h0; drive(s, "R8");
      // R10: compare and record forms
      s = blank(); s.kind = 3'd0; s.fpcc = 4'h8; s.cmp = 1'b1; s.rec = 1'b1; s.tgt = 3'd6;
      drive(s, "R10");
      s = blank(); s.kind = 3'd0; s.fpcc = 4'h4; s.rec = 1'b1; drive(s, "R10");
      // R2: non-sticky op flag bits are ignored
      s = blank(); s.kind = 3'd4; s.mask = 8'hFF; s.src = 32'h0; drive(s, "R8");
      s = blank(); s.kind = 3'd0; s.flags = 32'hE000_F8FF; s.fpcc = 4'h1; drive(s, "R2");
      // R12: reserved kinds and idle
      s = blank(); s.kind = 3'd6; drive(s, "R12");
      s = blank(); s.kind = 3'd7; drive(s, "R12");
      idle(3);

      // mixed stream
      for (int i = 0; i < 400; i++) begin
         string t;
         s = blank();
         s.kind = 3'($urandom_range(0, 7));
         s.flags = $urandom() & $urandom() & $urandom();
         s.fpcc = 4'($urandom()); s.rec = 1'($urandom()); s.cmp = 1'($urandom());
         s.bitn = 5'($urandom()); s.fld = 3'($urandom()); s.imm = 4'($urandom());
         s.mask = 8'($urandom()); s.src = $urandom() & $urandom();
         s.tgt = 3'($urandom());
         case (s.kind)
            3'd0: t = "R2"; 3'd1, 3'd2: t = "R6"; 3'd3: t = "R7";
            3'd4: t = "R8"; 3'd5: t = "R9"; default: t = "R12";
         endcase
         drive(s, t);
         if (($urandom() & 7) == 0) idle(1);
      end
      idle(4);
      done = 1'b1;
      if (sb.size() != 0) begin
         n_chk++; n_bad++;
         $display("FAIL R11 leftover: actual=%0d pending expected=0", sb.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule